// File: doc/BRIEF.md
# Mandelbrot Escape-Time Iteration Pipeline

This block works out the escape time of points in the complex plane. It applies z ← z² + c in signed fixed point, with 32-bit operands, 29 fraction bits and a range of [-4, 4). The datapath is a ring of nine register stages. Each stage holds at most one point, so up to nine independent points are in flight at once. A point goes round the ring once per iteration. On each trip the block squares the real and imaginary parts, forms twice their cross product, tests for escape and writes back the updated z. A point that is finished leaves the ring at the tail stage, and that ring position becomes free in the same cycle.

An upstream producer offers points with a load strobe. Each point carries its constant c and a screen position. A point is taken only in a cycle where `load_ready` is high, meaning the tail position is not carrying a point that is still iterating. A downstream result FIFO raises `fifo_almost_full` when it can no longer absorb the nine points that may already be in flight. That input blocks all new loads, because a finished point cannot be stalled inside the ring.

Each finished point produces a single-cycle result word. The word carries the in-set flag, the iteration count and the screen position.

Top module: `mandel_iter_pipe`

## Requirements
- R1: After reset, `res_valid` is 0 and `load_ready` is 1.
- R2: A point starts with z = 0 and an iteration count of 0. On each trip round the ring, real² + imag² of the current z is compared with 4.0. Each square is the 64-bit product shifted arithmetically right by 29. If the sum is 4.0 or more, the point leaves with in-set = 0 and its current count.
- R3: If the point has not escaped, z becomes (re² − im² + c_re, 2·re·im + c_im), truncated to 32 bits, and the count goes up by one. When the count reaches LIMIT (default 1024), the point leaves with in-set = 1 and count = LIMIT.
- R4: The result word is 37 bits. Bit 36 is the in-set flag, bits 35:20 the iteration count, bits 19:10 the vertical pixel and bits 9:0 the horizontal pixel.
- R5: A point accepted at clock edge E that leaves on its k-th trip has `res_valid` high for exactly the one cycle after edge E + 9·k.
- R6: The ring holds at most nine points. `load_ready` is 0 whenever the tail stage holds a point that is still iterating. A load offered while `load_ready` is 0 is ignored and produces no result.
- R7: While `fifo_almost_full` is 1, `load_ready` is 0 and loads are ignored.
- R8: In the cycle where a finished point sits at the tail, `load_ready` is 1 (if not inhibited), so that ring position can take a new point at once.
- R9: The pixel coordinates given with a point come back unchanged in its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Offer a new point this cycle |
| load_cre | input | 32 | Real part of c, signed Q2.29 |
| load_cim | input | 32 | Imaginary part of c, signed Q2.29 |
| load_vpix | input | 10 | Vertical pixel of the point |
| load_hpix | input | 10 | Horizontal pixel of the point |
| fifo_almost_full | input | 1 | Result FIFO cannot absorb nine more results; blocks loads |
| load_ready | output | 1 | A load offered this cycle is accepted |
| res_valid | output | 1 | Result word valid this cycle |
| res_word | output | 37 | Packed result (in-set, count, vertical, horizontal) |

## Verification
A point that leaves on trip k shows its result exactly 9·k edges after it was accepted. The bench counts edges from the accepting edge and samples at the falling edge. It requires the first high `res_valid` at 18 edges for c = 2 and at 27 edges for c = 1. `load_ready` follows the tail stage with no register in between. After nine loads back to back, the bench therefore expects it low at the falling edges after acceptance edges 8 through 16, and high after edge 17, when the first point leaves. Results from the nine-point table can arrive in any order, so they are matched by horizontal pixel. A refused load is shown to be dropped by checking that no result with its pixel ever appears.

// File: rtl/mandel_pkg.sv
package mandel_pkg;
    localparam int DATA_W  = 32;
    localparam int FRAC_W  = 29;
    localparam int PROD_W  = 2 * DATA_W;
    localparam int PIX_W   = 10;
    localparam int ITER_W  = 16;
    localparam int RES_W   = 1 + ITER_W + 2 * PIX_W;

    // 4.0 expressed at the rescaled product precision
    localparam logic signed [PROD_W-1:0] ESC_BOUND = PROD_W'(4) <<< FRAC_W;

    typedef struct packed {
        logic                     valid;
        logic                     done;
        logic                     inset;
        logic signed [DATA_W-1:0] cre;
        logic signed [DATA_W-1:0] cim;
        logic signed [DATA_W-1:0] zre;
        logic signed [DATA_W-1:0] zim;
        logic [ITER_W-1:0]        iter;
        logic [PIX_W-1:0]         vpix;
        logic [PIX_W-1:0]         hpix;
    } slot_t;

    typedef struct packed {
        logic signed [PROD_W-1:0] re_sq;
        logic signed [PROD_W-1:0] im_sq;
        logic signed [PROD_W-1:0] cross2;
    } prod_t;

    function automatic logic [RES_W-1:0] pack_result(input slot_t s);
        return {s.inset, s.iter, s.vpix, s.hpix};
    endfunction
endpackage

// File: rtl/mandel_mult_stage.sv
module mandel_mult_stage
    import mandel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  slot_t in_s,
    output slot_t out_s,
    output prod_t out_p
);
    logic signed [PROD_W-1:0] re_x, im_x;
    prod_t prod_c;

    always_comb begin
        re_x = PROD_W'(in_s.zre);
        im_x = PROD_W'(in_s.zim);
        prod_c.re_sq  = (re_x * re_x) >>> FRAC_W;
        prod_c.im_sq  = (im_x * im_x) >>> FRAC_W;
        // doubling folded into a one-bit-shorter shift
        prod_c.cross2 = (re_x * im_x) >>> (FRAC_W - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_s <= '0;
            out_p <= '0;
        end else begin
            out_s <= in_s;
            out_p <= prod_c;
        end
    end
endmodule

// File: rtl/mandel_update_stage.sv
module mandel_update_stage
    import mandel_pkg::*;
#(
    parameter int LIMIT = 1024
) (
    input  logic  clk,
    input  logic  rst,
    input  slot_t in_s,
    input  prod_t in_p,
    output slot_t out_s
);
    localparam logic [ITER_W-1:0] LIMIT_V = ITER_W'(LIMIT);

    logic signed [PROD_W-1:0] mag, re_nx, im_nx;
    logic [ITER_W-1:0]        iter_nx;
    logic                     escape;
    slot_t                    upd;

    always_comb begin
        mag     = in_p.re_sq + in_p.im_sq;
        escape  = (mag >= ESC_BOUND);
        re_nx   = in_p.re_sq - in_p.im_sq + PROD_W'(in_s.cre);
        im_nx   = in_p.cross2 + PROD_W'(in_s.cim);
        iter_nx = in_s.iter + 1'b1;
        upd     = in_s;
        if (in_s.valid) begin
            if (escape) begin
                upd.done  = 1'b1;
                upd.inset = 1'b0;
            end else begin
                upd.zre  = re_nx[DATA_W-1:0];
                upd.zim  = im_nx[DATA_W-1:0];
                upd.iter = iter_nx;
                if (iter_nx == LIMIT_V) begin
                    upd.done  = 1'b1;
                    upd.inset = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) out_s <= '0;
        else     out_s <= upd;
    end
endmodule

// File: rtl/mandel_iter_pipe.sv
module mandel_iter_pipe
    import mandel_pkg::*;
#(
    parameter int DEPTH = 9,
    parameter int LIMIT = 1024
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_en,
    input  logic signed [DATA_W-1:0] load_cre,
    input  logic signed [DATA_W-1:0] load_cim,
    input  logic [PIX_W-1:0]         load_vpix,
    input  logic [PIX_W-1:0]         load_hpix,
    input  logic                     fifo_almost_full,
    output logic                     load_ready,
    output logic                     res_valid,
    output logic [RES_W-1:0]         res_word
);
    localparam int TAIL = DEPTH - 1;

    slot_t ring [DEPTH];
    prod_t prods;
    slot_t entry_nx, fresh;
    logic  tail_exit, tail_recirc, accept;

    assign tail_exit   = ring[TAIL].valid && ring[TAIL].done;
    assign tail_recirc = ring[TAIL].valid && !ring[TAIL].done;
    assign load_ready  = !tail_recirc && !fifo_almost_full;
    assign accept      = load_en && load_ready;

    always_comb begin
        fresh       = '0;
        fresh.valid = 1'b1;
        fresh.cre   = load_cre;
        fresh.cim   = load_cim;
        fresh.vpix  = load_vpix;
        fresh.hpix  = load_hpix;
        if (tail_recirc) entry_nx = ring[TAIL];
        else if (accept) entry_nx = fresh;
        else             entry_nx = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) ring[0] <= '0;
        else     ring[0] <= entry_nx;
    end

    mandel_mult_stage u_mult (
        .clk(clk), .rst(rst), .in_s(ring[0]), .out_s(ring[1]), .out_p(prods)
    );

    mandel_update_stage #(.LIMIT(LIMIT)) u_upd (
        .clk(clk), .rst(rst), .in_s(ring[1]), .in_p(prods), .out_s(ring[2])
    );

    for (genvar g = 3; g < DEPTH; g++) begin : g_delay
        always_ff @(posedge clk) begin
            if (rst) ring[g] <= '0;
            else     ring[g] <= ring[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_word  <= '0;
        end else begin
            res_valid <= tail_exit;
            res_word  <= pack_result(ring[TAIL]);
        end
    end
endmodule

// File: rtl/mandel_iter_pipe_chk.sv
module mandel_iter_pipe_chk
    import mandel_pkg::*;
#(
    parameter int DEPTH = 9,
    parameter int LIMIT = 1024
) (
    input logic             clk,
    input logic             rst,
    input logic             load_en,
    input logic             load_ready,
    input logic             fifo_almost_full,
    input logic             res_valid,
    input logic [RES_W-1:0] res_word,
    input logic             tail_exit
);
    localparam int CNT_W = $clog2(DEPTH + 2) + 1;
    logic [CNT_W-1:0] in_flight;
    logic [ITER_W-1:0] r_iter;

    assign r_iter = res_word[RES_W-2 -: ITER_W];

    always_ff @(posedge clk) begin
        if (rst) in_flight <= '0;
        else     in_flight <= in_flight + CNT_W'(load_en && load_ready) - CNT_W'(tail_exit);
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !res_valid);
    p_escape_count_r2: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_word[RES_W-1]) |-> (r_iter >= 1 && r_iter < ITER_W'(LIMIT)));
    p_inset_count_r3: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_word[RES_W-1]) |-> (r_iter == ITER_W'(LIMIT)));
    p_capacity_r6: assert property (@(posedge clk) disable iff (rst)
        in_flight <= CNT_W'(DEPTH));
    p_inhibit_r7: assert property (@(posedge clk) disable iff (rst)
        fifo_almost_full |-> !load_ready);
endmodule

bind mandel_iter_pipe mandel_iter_pipe_chk #(.DEPTH(DEPTH), .LIMIT(LIMIT)) u_chk (
    .clk(clk), .rst(rst), .load_en(load_en), .load_ready(load_ready),
    .fifo_almost_full(fifo_almost_full), .res_valid(res_valid),
    .res_word(res_word), .tail_exit(tail_exit)
);

// File: tb/mandel_iter_pipe_tb_top.sv
module mandel_iter_pipe_tb_top;
    localparam int CLK_P  = 10;
    localparam int LIMIT  = 1024;
    localparam int NVEC   = 9;

    logic clk = 1'b0, rst = 1'b1, load_en = 1'b0, fifo_almost_full = 1'b0;
    logic signed [31:0] load_cre = '0, load_cim = '0;
    logic [9:0] load_vpix = '0, load_hpix = '0;
    logic load_ready, res_valid;
    logic [36:0] res_word;

    int checks = 0, failures = 0;
    bit finished = 0;

    // {c_re, c_im, inset, iter}
    localparam logic [80:0] VEC [NVEC] = '{
        {32'h40000000, 32'h00000000, 1'b0, 16'd1},
        {32'hC0000000, 32'h00000000, 1'b0, 16'd1},
        {32'h20000000, 32'h00000000, 1'b0, 16'd2},
        {32'h20000000, 32'h20000000, 1'b0, 16'd2},
        {32'h00000000, 32'hC0000000, 1'b0, 16'd1},
        {32'h10000000, 32'h00000000, 1'b0, 16'd5},
        {32'h00000000, 32'h00000000, 1'b1, 16'd1024},
        {32'hE0000000, 32'h00000000, 1'b1, 16'd1024},
        {32'h00000000, 32'h20000000, 1'b1, 16'd1024}
    };

    mandel_iter_pipe #(.DEPTH(9), .LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst(rst), .load_en(load_en), .load_cre(load_cre),
        .load_cim(load_cim), .load_vpix(load_vpix), .load_hpix(load_hpix),
        .fifo_almost_full(fifo_almost_full), .load_ready(load_ready),
        .res_valid(res_valid), .res_word(res_word)
    );

    always #(CLK_P/2) clk = ~clk;

    logic [36:0] log_w [64];
    int log_n = 0;
    always @(negedge clk) begin
        if (!rst && res_valid && log_n < 64) begin
            log_w[log_n] = res_word;
            log_n = log_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] cr, input logic [31:0] ci, input logic [9:0] v, input logic [9:0] h);
        load_en = 1'b1; load_cre = cr; load_cim = ci; load_vpix = v; load_hpix = h;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wait_result(output int k, output logic [36:0] w);
        k = 0;
        while (!res_valid && k < 20000) begin step(); k++; end
        w = res_word;
    endtask

    int k;
    logic [36:0] w;
    int base, found, hits;

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
        check(load_ready == 1'b1, "R1 load_ready", load_ready, 1);

        // R5/R2: c = 2 escapes on trip 2 with count 1
        drive(32'h40000000, 0, 10'd7, 10'd9); step(); load_en = 1'b0;
        wait_result(k, w);
        check(k == 18, "R5 latency c=2", k, 18);
        check(w == {1'b0, 16'd1, 10'd7, 10'd9}, "R2/R4 word c=2", w, {1'b0, 16'd1, 10'd7, 10'd9});
        step();
        check(res_valid == 1'b0, "R5 single-cycle pulse", res_valid, 0);

        // R5: c = 1 escapes on trip 3
        drive(32'h20000000, 0, 10'd1, 10'd2); step(); load_en = 1'b0;
        wait_result(k, w);
        check(k == 27, "R5 latency c=1", k, 27);
        check(w[35:20] == 16'd2, "R2 count c=1", w[35:20], 2);
        repeat (3) step();

        // R7: inhibit blocks loads
        fifo_almost_full = 1'b1;
        @(negedge clk);
        check(load_ready == 1'b0, "R7 ready low", load_ready, 0);
        base = log_n;
        drive(32'h40000000, 0, 10'd3, 10'd3); repeat (3) step(); load_en = 1'b0;
        repeat (40) step();
        check(log_n == base, "R7 ignored load", log_n - base, 0);
        fifo_almost_full = 1'b0;
        step();

        // Table walk: nine points back to back fill the ring
        base = log_n;
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][80:49], VEC[i][48:17], 10'(700 + 5*i), 10'(3 + 37*i));
            step();
        end
        // now at falling edge after acceptance edge 8
        check(load_ready == 1'b0, "R6 ring full ready low", load_ready, 0);
        drive(32'h40000000, 0, 10'd0, 10'd1000); step(); load_en = 1'b0;  // edge 9, refused
        for (int e = 10; e <= 16; e++) step();
        check(load_ready == 1'b0, "R6 ready low edge 16", load_ready, 0);
        step();
        check(load_ready == 1'b1, "R8 exiting slot frees", load_ready, 1);

        k = 0;
        while (log_n < base + NVEC && k < 12000) begin step(); k++; end
        repeat (50) step();
        check(log_n - base == NVEC, "R6 result count", log_n - base, NVEC);
        hits = 0;
        for (int j = base; j < log_n; j++) if (log_w[j][9:0] == 10'd1000) hits++;
        check(hits == 0, "R6 refused load absent", hits, 0);

        for (int i = 0; i < NVEC; i++) begin
            found = -1;
            for (int j = base; j < log_n; j++)
                if (log_w[j][9:0] == 10'(3 + 37*i)) found = j;
            check(found >= 0, "R9 result present", found, i);
            if (found >= 0) begin
                check(log_w[found][19:10] == 10'(700 + 5*i), "R9 vpix", log_w[found][19:10], 700 + 5*i);
                check(log_w[found][36] == VEC[i][16], VEC[i][16] ? "R3 inset flag" : "R2 inset flag",
                      log_w[found][36], VEC[i][16]);
                check(log_w[found][35:20] == VEC[i][15:0], VEC[i][16] ? "R3 count" : "R2 count",
                      log_w[found][35:20], VEC[i][15:0]);
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule